// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned operands and reports whether the first is greater than, equal to or smaller than the second. The result comes out as three one-hot flags. It is built from narrow comparison slices. Each slice takes a three-flag relation input that settles a tie. When the slice's own operand bits are equal, it passes that relation through. When they differ, it reports its own verdict and ignores the input.

The default build is a 16-bit comparator made of four 4-bit slices. A parameter selects one of two ways to connect them.

- **Serial chain:** the relation ripples from the least significant slice up to the most significant one. Slice 3 covers bits 15:12.
- **Two-level tree:** four first-level slices each see a neutral "equal" relation. Their greater flags form a vector g and their smaller flags form a vector s. A second-level slice compares g against s.

In both forms the external relation input enters where a full tie is resolved. For a plain comparison, drive it with the neutral relation: greater 0, equal 1, smaller 0. The block is purely combinational.

Top module: `mag_cmp16`

## Requirements
- R1: When the operands differ, the result is decided by the most significant bit position in which they differ. The result is greater when `a_i` holds 1 at that position, and smaller when `a_i` holds 0.
- R2: When `a_i` equals `b_i`, the outputs (`gt_o`, `eq_o`, `lt_o`) copy the relation inputs (`rel_gt_i`, `rel_eq_i`, `rel_lt_i`).
- R3: When `a_i` > `b_i` as unsigned numbers, `gt_o` is 1 and the other two outputs are 0, whatever the relation inputs hold.
- R4: When `a_i` < `b_i` as unsigned numbers, `lt_o` is 1 and the other two outputs are 0, whatever the relation inputs hold.
- R5: `eq_o` is 1 only when the operands are equal and `rel_eq_i` is 1.
- R6: Whenever exactly one relation input is 1, exactly one of the three outputs is 1.
- R7: Slices are ordered by significance, and bits 15:12 outweigh every lower slice. For example, 0x1000 against 0x0FFF gives greater, and 0x0FFF against 0x1000 gives smaller.
- R8: With `TREE_MODE` = 1 (two-level tree) the outputs equal those of `TREE_MODE` = 0 (serial chain) for every operand pair and every one-hot relation input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First unsigned operand |
| b_i | input | 16 | Second unsigned operand |
| rel_gt_i | input | 1 | Relation input: tie resolves to greater |
| rel_eq_i | input | 1 | Relation input: tie resolves to equal |
| rel_lt_i | input | 1 | Relation input: tie resolves to smaller |
| gt_o | output | 1 | First operand is greater |
| eq_o | output | 1 | Operands are equal and the relation input is equal |
| lt_o | output | 1 | First operand is smaller |

## Verification
In any one evaluation, two decisions can compete for the outputs: the slices' own operand verdict and the relation input. They meet when operands that differ in only one low bit are paired with a non-neutral relation input. They also meet when the top slice and a lower slice disagree, such as 0x1000 against 0x0FFF. These cases show whether the operand verdict correctly overrides the tie relation. The bench drives both the chain and the tree build with the same stimulus. Every result is judged against an integer compare and against a one-hot rule, and the two builds are required to agree with each other.

// File: rtl/mag_cmp_pkg.sv
`timescale 1ns/1ps
package mag_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_NEUTRAL = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

  // Relation that a single bit pair contributes.
  function automatic rel_t bit_rel(input logic x, input logic y);
    rel_t r;
    r.gt = x & ~y;
    r.lt = ~x & y;
    r.eq = ~(x ^ y);
    return r;
  endfunction

  // Upper part wins unless it ties, then the lower part decides.
  function automatic rel_t merge_rel(input rel_t hi, input rel_t lo);
    rel_t r;
    r.gt = hi.gt | (hi.eq & lo.gt);
    r.lt = hi.lt | (hi.eq & lo.lt);
    r.eq = hi.eq & lo.eq;
    return r;
  endfunction

endpackage

// File: rtl/cmp_bit_cells.sv
`timescale 1ns/1ps
module cmp_bit_cells
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] e_o,
  output logic [W-1:0] s_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    rel_t r;
    assign r      = bit_rel(x_i[i], y_i[i]);
    assign g_o[i] = r.gt;
    assign e_o[i] = r.eq;
    assign s_o[i] = r.lt;
  end
endmodule

// File: rtl/cmp_slice.sv
`timescale 1ns/1ps
module cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  rel_t         rel_i,
  output rel_t         rel_o
);
  logic [W-1:0] g_bits, e_bits, s_bits;

  cmp_bit_cells #(.W(W)) u_cells (
    .x_i(x_i), .y_i(y_i),
    .g_o(g_bits), .e_o(e_bits), .s_o(s_bits)
  );

  // Priority sum of products from the top bit down, relation input last.
  always_comb begin
    logic run, gacc, sacc;
    run  = 1'b1;
    gacc = 1'b0;
    sacc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      gacc = gacc | (run & g_bits[i]);
      sacc = sacc | (run & s_bits[i]);
      run  = run & e_bits[i];
    end
    rel_o.gt = gacc | (run & rel_i.gt);
    rel_o.lt = sacc | (run & rel_i.lt);
    rel_o.eq = run & rel_i.eq;
  end
endmodule

// File: rtl/cmp_chain.sv
`timescale 1ns/1ps
module cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  rel_t              rel_i,
  output rel_t              rel_o
);
  rel_t link [NUM_SLICES+1];
  assign link[0] = rel_i;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_stage
    cmp_slice #(.W(SLICE_W)) u_slice (
      .x_i  (a_i[k*SLICE_W +: SLICE_W]),
      .y_i  (b_i[k*SLICE_W +: SLICE_W]),
      .rel_i(link[k]),
      .rel_o(link[k+1])
    );
  end

  assign rel_o = link[NUM_SLICES];
endmodule

// File: rtl/cmp_tree.sv
`timescale 1ns/1ps
module cmp_tree
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  localparam int DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  rel_t              rel_i,
  output rel_t              rel_o
);
  logic [NUM_SLICES-1:0] grt_vec;
  logic [NUM_SLICES-1:0] sml_vec;
  logic [NUM_SLICES-1:0] tie_vec;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_leaf
    rel_t leaf;
    cmp_slice #(.W(SLICE_W)) u_leaf (
      .x_i  (a_i[k*SLICE_W +: SLICE_W]),
      .y_i  (b_i[k*SLICE_W +: SLICE_W]),
      .rel_i(REL_NEUTRAL),
      .rel_o(leaf)
    );
    // Vector index k follows operand significance.
    assign grt_vec[k] = leaf.gt;
    assign sml_vec[k] = leaf.lt;
    assign tie_vec[k] = leaf.eq;
  end

  cmp_slice #(.W(NUM_SLICES)) u_root (
    .x_i  (grt_vec),
    .y_i  (sml_vec),
    .rel_i(rel_i),
    .rel_o(rel_o)
  );

  logic unused_tie;
  assign unused_tie = ^tie_vec;
endmodule

// File: rtl/mag_cmp16.sv
`timescale 1ns/1ps
module mag_cmp16
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W   = 4,
  parameter int DATA_W    = 16,
  parameter int TREE_MODE = 0
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              rel_gt_i,
  input  logic              rel_eq_i,
  input  logic              rel_lt_i,
  output logic              gt_o,
  output logic              eq_o,
  output logic              lt_o
);
  localparam int NUM_SLICES = DATA_W / SLICE_W;

  rel_t cas_rel;
  rel_t res_rel;

  assign cas_rel = '{gt: rel_gt_i, eq: rel_eq_i, lt: rel_lt_i};

  if (TREE_MODE != 0) begin : g_tree
    cmp_tree #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_net (
      .a_i(a_i), .b_i(b_i), .rel_i(cas_rel), .rel_o(res_rel)
    );
  end else begin : g_chain
    cmp_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_net (
      .a_i(a_i), .b_i(b_i), .rel_i(cas_rel), .rel_o(res_rel)
    );
  end

  assign gt_o = res_rel.gt;
  assign eq_o = res_rel.eq;
  assign lt_o = res_rel.lt;
endmodule

// File: rtl/mag_cmp16_chk.sv
`timescale 1ns/1ps
module mag_cmp16_chk #(
  parameter int DATA_W = 16
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              rel_gt_i,
  input logic              rel_eq_i,
  input logic              rel_lt_i,
  input logic              gt_o,
  input logic              eq_o,
  input logic              lt_o
);
  logic known;
  assign known = !$isunknown({a_i, b_i, rel_gt_i, rel_eq_i, rel_lt_i, gt_o, eq_o, lt_o});

  always_comb begin
    if (known) begin
      p_greater_wins_r3: assert (!(a_i > b_i) || (gt_o && !eq_o && !lt_o));
      p_smaller_wins_r4: assert (!(a_i < b_i) || (lt_o && !eq_o && !gt_o));
      p_tie_copies_r2: assert (!(a_i == b_i) ||
                               ({gt_o, eq_o, lt_o} == {rel_gt_i, rel_eq_i, rel_lt_i}));
      p_eq_needs_tie_r5: assert (!eq_o || (a_i == b_i && rel_eq_i));
      p_onehot_out_r6: assert ($countones({rel_gt_i, rel_eq_i, rel_lt_i}) != 1 ||
                               $countones({gt_o, eq_o, lt_o}) == 1);
      p_top_slice_r7: assert (!(a_i[DATA_W-1 -: 4] > b_i[DATA_W-1 -: 4]) || gt_o);
    end
  end
endmodule

bind mag_cmp16 mag_cmp16_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mag_cmp16_bench.sv
`timescale 1ns/1ps
module mag_cmp16_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a, b;
  logic rg, re, rl;
  logic c_gt, c_eq, c_lt, t_gt, t_eq, t_lt;

  mag_cmp16 #(.TREE_MODE(0)) u_mag_cmp16 (
    .a_i(a), .b_i(b), .rel_gt_i(rg), .rel_eq_i(re), .rel_lt_i(rl),
    .gt_o(c_gt), .eq_o(c_eq), .lt_o(c_lt));

  mag_cmp16 #(.TREE_MODE(1)) u_mag_cmp16_tree (
    .a_i(a), .b_i(b), .rel_gt_i(rg), .rel_eq_i(re), .rel_lt_i(rl),
    .gt_o(t_gt), .eq_o(t_eq), .lt_o(t_lt));

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [2:0] model(input logic [15:0] x, input logic [15:0] y,
                                       input logic [2:0] cas);
    if (x > y) return 3'b100;
    if (x < y) return 3'b001;
    return cas;
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y,
                       input logic [2:0] cas, input string tag);
    item_t it;
    @(negedge clk);
    a = x; b = y; {rg, re, rl} = cas;
    it.exp = model(x, y, cas);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares both builds at the edge after the inputs settled.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if ({c_gt, c_eq, c_lt} !== it.exp) begin
          errors++;
          $display("FAIL %s chain a=%h b=%h got %b exp %b", it.tag, a, b,
                   {c_gt, c_eq, c_lt}, it.exp);
        end
        checks++;
        if ({t_gt, t_eq, t_lt} !== {c_gt, c_eq, c_lt}) begin
          errors++;
          $display("FAIL R8 tree a=%h b=%h got %b exp %b", a, b,
                   {t_gt, t_eq, t_lt}, {c_gt, c_eq, c_lt});
        end
        if ($countones({rg, re, rl}) == 1) begin
          checks++;
          if ($countones({t_gt, t_eq, t_lt}) != 1 || $countones({c_gt, c_eq, c_lt}) != 1) begin
            errors++;
            $display("FAIL R6 onehot got chain %b tree %b exp one bit set",
                     {c_gt, c_eq, c_lt}, {t_gt, t_eq, t_lt});
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog got %0d cycles exp fewer", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    a = '0; b = '0; {rg, re, rl} = 3'b010;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(16'h0000, 16'h0000, 3'b010, "R5 reset-state zeros");
    drive(16'hFFFF, 16'hFFFF, 3'b010, "R5 all ones equal");
    drive(16'h1234, 16'h1234, 3'b100, "R2 tie to greater");
    drive(16'h1234, 16'h1234, 3'b001, "R2 tie to smaller");
    drive(16'hFFFF, 16'h0000, 3'b001, "R3 max vs zero");
    drive(16'h0000, 16'hFFFF, 3'b100, "R4 zero vs max");
    drive(16'h1000, 16'h0FFF, 3'b001, "R7 top slice greater");
    drive(16'h0FFF, 16'h1000, 3'b100, "R7 top slice smaller");
    drive(16'h0100, 16'h00FF, 3'b010, "R7 middle slice");
    for (int i = 0; i < 16; i++) begin
      drive(16'h5A5A | (16'h1 << i), 16'h5A5A & ~(16'h1 << i), 3'b001, "R1 single bit a high");
      drive(16'hA5A5 & ~(16'h1 << i), 16'hA5A5 | (16'h1 << i), 3'b100, "R1 single bit b high");
    end
    for (int i = 0; i < 300; i++) begin
      logic [15:0] x, y;
      logic [2:0] cas;
      x = 16'($urandom);
      y = (i % 4 == 0) ? x : 16'($urandom);
      if (i % 5 == 1) y = x ^ (16'h1 << (i % 16));
      cas = 3'b001 << (i % 3);
      drive(x, y, cas, (x > y) ? "R3 random" : (x < y) ? "R4 random" : "R2 random");
    end
    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule